// File: doc/BRIEF.md
# Processor Reset Controller with Cause Logging

This block drives the reset lines of a four-processor system from a small register space. Software can request a power-on reset (POR) for any single processor or for the whole system. It can also request an externally initiated reset (XIR) for single processors. Hardware events can also reset the whole system: a debug-port reset, a push-button, a remote monitor, fatal errors from seven bus agents, a clock-synthesizer reprogram and a watchdog expiry. The watchdog acts only when its action bit is set, and fatal errors from the four processors can be masked one by one.

Two read-only registers record what caused the most recent POR and the most recent XIR. In any cycle with a new event, the matching cause register is overwritten with exactly that cycle's event bits, so stale causes never pile up. The power-up reset (`rst_n` low, asynchronous) clears every control register and leaves only the power-up bit set in the POR cause register. The register bus has no handshake: a write takes effect at the clock edge where `reg_we` is high, and read data follows `reg_addr` in the same cycle. Register map: 0 soft POR, 1 soft XIR, 2 watchdog action, 3 quiesce mask, 4 synthesizer control, 5 POR cause, 6 XIR cause, 7 reads zero. Writes to 5–7 are ignored.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While and after `rst_n` is low, all outputs are low and registers 0–4 and 6 read zero. Register 5 reads 0x80 (only bit 7, power-up).
- R2: A write to register 0 with bits 3:0 non-zero asserts `cpu_por_o[i]` for each set bit i. The assertion starts in the cycle after the write edge and lasts exactly 16 cycles. Register 0 then reads zero again, and POR cause bits 3:0 copy the written bits.
- R3: Register 0 bit 4 asserts `sys_rst_o` and all four `cpu_por_o` for the same 16-cycle window and sets POR cause bit 4. Whenever `sys_rst_o` is high, every `cpu_por_o` bit is high.
- R4: A write to register 1 with bits 3:0 non-zero asserts the matching `cpu_xir_o` bits for 16 cycles and loads XIR cause bits 3:0 with them.
- R5: A write to register 0 or 1 while that register's pulse is running is ignored, and so is a write of zero. Register bits 7:5 of register 0 and bits 7:4 of register 1 are dropped.
- R6: `jtag_por_i`, `btn_por_i` and `remote_i` assert `sys_rst_o` and all `cpu_por_o` in the next cycle. The POR cause register is then replaced by exactly that cycle's event bits: 5 debug-port, 6 button, 17 remote.
- R7: With register 2 bit 0 set, `wdog_i` causes a system reset and POR cause bit 16. With that bit clear, `wdog_i` changes neither outputs nor cause.
- R8: `fatal_i[k]` causes a system reset and POR cause bit 8+k. For k = 0..3, register 3 bit 4+k masks it, and a masked line gives neither reset nor cause bit. Register 3 bits 3:0 are stored but have no effect.
- R9: When register 4 bits 7 and 0 become both set, `sys_rst_o` pulses for one cycle, two cycles after the write edge, and POR cause becomes bit 15 only. Either bit alone does nothing.
- R10: `jtag_xir_i` and `btn_xir_i` assert all `cpu_xir_o` in the next cycle and load XIR cause bit 4 and bit 5 respectively.
- R11: Reads return each register's current value zero-extended to 32 bits, and unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| wdog_i | input | 1 | Watchdog expiry line |
| jtag_por_i | input | 1 | Debug-port system reset request |
| btn_por_i | input | 1 | Push-button system reset request |
| remote_i | input | 1 | Remote monitor system reset request |
| fatal_i | input | 7 | Fatal error lines from agents 0–6 |
| jtag_xir_i | input | 1 | Debug-port XIR to all processors |
| btn_xir_i | input | 1 | Button XIR to all processors |
| cpu_por_o | output | 4 | Per-processor power-on reset |
| cpu_xir_o | output | 4 | Per-processor externally initiated reset |
| sys_rst_o | output | 1 | System reset |

## Verification
Soft POR and XIR pulses appear in the cycle after the write edge and last exactly sixteen cycles. Reset outputs driven by input lines follow one cycle after the line. The synthesizer reset is due two cycles after its write. Each cause register changes at the same edge as the output it explains. The bench moves its reference model at every rising edge and compares all outputs and the addressed read data at the following falling edge. Inputs change one nanosecond after that falling edge, so every expected value lines up with the edge that produced it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int N_CPU   = 4;
  localparam int N_AGENT = 7;
  localparam int AW      = 3;
  localparam int DW      = 8;
  localparam int RW      = 32;
  localparam int PCW     = 18;
  localparam int XCW     = 6;

  localparam logic [AW-1:0] A_SOFT_POR = 3'd0;
  localparam logic [AW-1:0] A_SOFT_XIR = 3'd1;
  localparam logic [AW-1:0] A_WD_ACT   = 3'd2;
  localparam logic [AW-1:0] A_QUIESCE  = 3'd3;
  localparam logic [AW-1:0] A_SYNTH    = 3'd4;
  localparam logic [AW-1:0] A_POR_SRC  = 3'd5;
  localparam logic [AW-1:0] A_XIR_SRC  = 3'd6;

  localparam int PC_SYS    = 4;
  localparam int PC_JTAG   = 5;
  localparam int PC_BTN    = 6;
  localparam int PC_PWR    = 7;
  localparam int PC_FATAL  = 8;
  localparam int PC_SYNTH  = 15;
  localparam int PC_WDOG   = 16;
  localparam int PC_REMOTE = 17;
  localparam int XC_JTAG   = 4;
  localparam int XC_BTN    = 5;

  localparam int QM_LSB    = 4;
  localparam int SY_LOAD   = 0;
  localparam int SY_ROL    = 7;

  localparam logic [PCW-1:0] POR_SRC_PWRUP = PCW'(1) << PC_PWR;
endpackage

// File: rtl/rstc_pulse_reg.sv
module rstc_pulse_reg #(
  parameter int W         = 4,
  parameter int PULSE_LEN = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         accept
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign accept = wr_en && (q == '0) && (wdata != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      q     <= wdata;
      cnt_q <= LAST;
    end else if (q != '0) begin
      if (cnt_q == '0) q <= '0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rstc_cause_log.sv
module rstc_cause_log #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  output logic [W-1:0] cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause <= RST_VAL;
    else if (ev != '0) cause <= ev;
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [RW-1:0]      reg_rdata,
  input  logic               wdog_i,
  input  logic               jtag_por_i,
  input  logic               btn_por_i,
  input  logic               remote_i,
  input  logic [N_AGENT-1:0] fatal_i,
  input  logic               jtag_xir_i,
  input  logic               btn_xir_i,
  output logic [N_CPU-1:0]   cpu_por_o,
  output logic [N_CPU-1:0]   cpu_xir_o,
  output logic               sys_rst_o
);
  localparam int NREG = 1 << AW;
  localparam int PW   = N_CPU + 1;

  logic [NREG-1:0]    wsel;
  logic [PW-1:0]      soft_por_q;
  logic [N_CPU-1:0]   soft_xir_q;
  logic               por_acc, xir_acc;
  logic               wd_act_q;
  logic [DW-1:0]      quiesce_q;
  logic               syn_load_q, syn_rol_q, syn_cond_d;
  logic               syn_cond;
  logic [N_AGENT-1:0] fatal_mask, fatal_eff;
  logic [PCW-1:0]     por_ev, por_cause;
  logic [XCW-1:0]     xir_ev, xir_cause;
  logic               sys_ev_q, xir_all_q;

  for (genvar a = 0; a < NREG; a++) begin : g_wsel
    assign wsel[a] = reg_we && (reg_addr == AW'(a));
  end

  rstc_pulse_reg #(.W(PW), .PULSE_LEN(PULSE_LEN)) u_soft_por (
    .clk(clk), .rst_n(rst_n), .wr_en(wsel[A_SOFT_POR]),
    .wdata(reg_wdata[PW-1:0]), .q(soft_por_q), .accept(por_acc)
  );

  rstc_pulse_reg #(.W(N_CPU), .PULSE_LEN(PULSE_LEN)) u_soft_xir (
    .clk(clk), .rst_n(rst_n), .wr_en(wsel[A_SOFT_XIR]),
    .wdata(reg_wdata[N_CPU-1:0]), .q(soft_xir_q), .accept(xir_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_act_q   <= 1'b0;
      quiesce_q  <= '0;
      syn_load_q <= 1'b0;
      syn_rol_q  <= 1'b0;
      syn_cond_d <= 1'b0;
      sys_ev_q   <= 1'b0;
      xir_all_q  <= 1'b0;
    end else begin
      if (wsel[A_WD_ACT])  wd_act_q  <= reg_wdata[0];
      if (wsel[A_QUIESCE]) quiesce_q <= reg_wdata;
      if (wsel[A_SYNTH]) begin
        syn_load_q <= reg_wdata[SY_LOAD];
        syn_rol_q  <= reg_wdata[SY_ROL];
      end
      syn_cond_d <= syn_cond;
      sys_ev_q   <= |por_ev[PCW-1:PC_JTAG];
      xir_all_q  <= jtag_xir_i | btn_xir_i;
    end
  end

  assign syn_cond   = syn_load_q && syn_rol_q;
  assign fatal_mask = {{(N_AGENT-N_CPU){1'b0}}, quiesce_q[QM_LSB +: N_CPU]};
  assign fatal_eff  = fatal_i & ~fatal_mask;

  always_comb begin
    por_ev = '0;
    if (por_acc) por_ev[PW-1:0] = reg_wdata[PW-1:0];
    por_ev[PC_JTAG]                   = jtag_por_i;
    por_ev[PC_BTN]                    = btn_por_i;
    por_ev[PC_FATAL +: N_AGENT]       = fatal_eff;
    por_ev[PC_SYNTH]                  = syn_cond && !syn_cond_d;
    por_ev[PC_WDOG]                   = wdog_i && wd_act_q;
    por_ev[PC_REMOTE]                 = remote_i;
    xir_ev = '0;
    if (xir_acc) xir_ev[N_CPU-1:0] = reg_wdata[N_CPU-1:0];
    xir_ev[XC_JTAG] = jtag_xir_i;
    xir_ev[XC_BTN]  = btn_xir_i;
  end

  rstc_cause_log #(.W(PCW), .RST_VAL(POR_SRC_PWRUP)) u_por_log (
    .clk(clk), .rst_n(rst_n), .ev(por_ev), .cause(por_cause)
  );

  rstc_cause_log #(.W(XCW), .RST_VAL('0)) u_xir_log (
    .clk(clk), .rst_n(rst_n), .ev(xir_ev), .cause(xir_cause)
  );

  assign sys_rst_o = soft_por_q[N_CPU] | sys_ev_q;
  assign cpu_por_o = soft_por_q[N_CPU-1:0] | {N_CPU{sys_rst_o}};
  assign cpu_xir_o = soft_xir_q | {N_CPU{xir_all_q}};

  always_comb begin
    unique case (reg_addr)
      A_SOFT_POR: reg_rdata = RW'(soft_por_q);
      A_SOFT_XIR: reg_rdata = RW'(soft_xir_q);
      A_WD_ACT:   reg_rdata = RW'(wd_act_q);
      A_QUIESCE:  reg_rdata = RW'(quiesce_q);
      A_SYNTH:    reg_rdata = RW'({syn_rol_q, 6'b0, syn_load_q});
      A_POR_SRC:  reg_rdata = RW'(por_cause);
      A_XIR_SRC:  reg_rdata = RW'(xir_cause);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk
  import rstc_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdog_i,
  input logic             jtag_por_i,
  input logic             jtag_xir_i,
  input logic             btn_xir_i,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [N_CPU-1:0] cpu_por_o,
  input logic             sys_rst_o,
  input logic             wd_act_q,
  input logic [N_CPU:0]   soft_por_q,
  input logic [PCW-1:0]   por_cause,
  input logic [XCW-1:0]   xir_cause
);
  localparam int RCW = $clog2(PULSE_LEN + 2);
  localparam logic [RCW-1:0] PL = RCW'(PULSE_LEN);

  logic [RCW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (|soft_por_q)  run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  // R2: a soft POR pulse lasts exactly PULSE_LEN cycles
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|soft_por_q) |-> (run_q == PL));

  // R3: system reset always reaches every processor
  p_sys_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (cpu_por_o == '1));

  // R6: debug-port reset is logged and applied next cycle
  p_jtag_por_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jtag_por_i |=> (sys_rst_o && por_cause[PC_JTAG]));

  // R6: the cause register never becomes empty
  p_cause_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    por_cause != '0);

  // R7: armed watchdog resets the system
  p_wd_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_i && wd_act_q) |=> (sys_rst_o && por_cause[PC_WDOG]));

  // R10: XIR cause holds when no XIR source is active
  p_xir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!jtag_xir_i && !btn_xir_i && !(reg_we && reg_addr == A_SOFT_XIR))
      |=> $stable(xir_cause));
endmodule

bind rst_cause_ctrl rstc_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdog_i(wdog_i), .jtag_por_i(jtag_por_i),
  .jtag_xir_i(jtag_xir_i), .btn_xir_i(btn_xir_i), .reg_we(reg_we),
  .reg_addr(reg_addr), .cpu_por_o(cpu_por_o), .sys_rst_o(sys_rst_o),
  .wd_act_q(wd_act_q), .soft_por_q(soft_por_q), .por_cause(por_cause),
  .xir_cause(xir_cause)
);

// File: tb/rst_cause_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd5;
  logic [7:0]  reg_wdata = 8'd0;
  logic [31:0] reg_rdata;
  logic        wdog_i = 0, jtag_por_i = 0, btn_por_i = 0, remote_i = 0;
  logic [6:0]  fatal_i = '0;
  logic        jtag_xir_i = 0, btn_xir_i = 0;
  logic [3:0]  cpu_por_o, cpu_xir_o;
  logic        sys_rst_o;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_cause_ctrl dut_i (.*);

  // reference model state
  int m_por, m_por_left, m_xir, m_xir_left, m_wd, m_qui, m_ld, m_rol, m_cond_d;
  int m_sys, m_xall, m_pc, m_xc;

  task automatic model_reset();
    m_por = 0; m_por_left = 0; m_xir = 0; m_xir_left = 0; m_wd = 0; m_qui = 0;
    m_ld = 0; m_rol = 0; m_cond_d = 0; m_sys = 0; m_xall = 0;
    m_pc = 'h80; m_xc = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int ev, xe, cond;
      bit acc_p, acc_x;
      acc_p = reg_we && reg_addr == 0 && m_por == 0 && (reg_wdata & 'h1f) != 0;
      acc_x = reg_we && reg_addr == 1 && m_xir == 0 && (reg_wdata & 'hf) != 0;
      cond  = m_ld & m_rol;
      ev = 0;
      if (acc_p) ev = reg_wdata & 'h1f;
      if (jtag_por_i) ev |= 1 << 5;
      if (btn_por_i) ev |= 1 << 6;
      for (int k = 0; k < 7; k++)
        if (fatal_i[k] && !(k < 4 && m_qui[4+k])) ev |= 1 << (8 + k);
      if (cond && !m_cond_d) ev |= 1 << 15;
      if (wdog_i && m_wd) ev |= 1 << 16;
      if (remote_i) ev |= 1 << 17;
      xe = 0;
      if (acc_x) xe = reg_wdata & 'hf;
      if (jtag_xir_i) xe |= 1 << 4;
      if (btn_xir_i) xe |= 1 << 5;
      m_sys  = (ev >> 5) != 0;
      m_xall = jtag_xir_i || btn_xir_i;
      if (acc_p) begin m_por = reg_wdata & 'h1f; m_por_left = 16; end
      else if (m_por_left > 0) begin
        m_por_left--; if (m_por_left == 0) m_por = 0;
      end
      if (acc_x) begin m_xir = reg_wdata & 'hf; m_xir_left = 16; end
      else if (m_xir_left > 0) begin
        m_xir_left--; if (m_xir_left == 0) m_xir = 0;
      end
      m_cond_d = cond;
      if (reg_we && reg_addr == 2) m_wd = reg_wdata[0];
      if (reg_we && reg_addr == 3) m_qui = reg_wdata;
      if (reg_we && reg_addr == 4) begin m_ld = reg_wdata[0]; m_rol = reg_wdata[7]; end
      if (ev != 0) m_pc = ev;
      if (xe != 0) m_xc = xe;
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return m_por;
      1: return m_xir;
      2: return m_wd;
      3: return m_qui;
      4: return (m_rol << 7) | m_ld;
      5: return m_pc;
      6: return m_xc;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) if (!done) begin
    int e_sys, e_por, e_xir;
    e_sys = ((m_por >> 4) & 1) | m_sys;
    e_por = (m_por & 'hf) | (e_sys ? 'hf : 0);
    e_xir = m_xir | (m_xall ? 'hf : 0);
    cmp("sys_rst_o", sys_rst_o, e_sys);
    cmp("cpu_por_o", cpu_por_o, e_por);
    cmp("cpu_xir_o", cpu_xir_o, e_xir);
    cmp("reg_rdata", reg_rdata, model_read(reg_addr));
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic idle(input int n); repeat (n) step(); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(); reg_we = 1; reg_addr = a; reg_wdata = d;
    step(); reg_we = 0; reg_addr = 3'd5;
  endtask
  task automatic rd(input logic [2:0] a, input int exp, input string req);
    step(); reg_addr = a;
    @(negedge clk); cur_req = req; cmp("explicit read", reg_rdata, exp);
    #1 reg_addr = 3'd5;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1"; idle(3); rst_n = 1; idle(2);
    rd(3'd5, 'h80, "R1"); rd(3'd0, 0, "R1"); rd(3'd6, 0, "R1");
    cur_req = "R2"; wr(3'd0, 8'h05); idle(20); rd(3'd5, 'h05, "R2");
    cur_req = "R5"; wr(3'd0, 8'h02); wr(3'd0, 8'h08); idle(5);
    wr(3'd0, 8'h00); idle(20); wr(3'd1, 8'hF0); idle(3);
    cur_req = "R11"; wr(3'd0, 8'hE1); rd(3'd0, 'h01, "R11"); idle(18);
    cur_req = "R3"; wr(3'd0, 8'h10); idle(20); rd(3'd5, 'h10, "R3");
    cur_req = "R4"; wr(3'd1, 8'h0A); idle(20); rd(3'd6, 'h0A, "R4");
    cur_req = "R10"; reg_addr = 3'd6;
    step(); jtag_xir_i = 1; step(); jtag_xir_i = 0; idle(3);
    step(); btn_xir_i = 1; step(); step(); btn_xir_i = 0; idle(3);
    reg_addr = 3'd5;
    cur_req = "R6";
    step(); jtag_por_i = 1; step(); jtag_por_i = 0; idle(3);
    step(); btn_por_i = 1; step(); btn_por_i = 0; idle(3);
    step(); remote_i = 1; jtag_por_i = 1; step(); remote_i = 0; jtag_por_i = 0; idle(3);
    rd(3'd5, 'h20020, "R6");
    cur_req = "R7";
    step(); wdog_i = 1; idle(3); wdog_i = 0; idle(2);
    wr(3'd2, 8'h01); step(); wdog_i = 1; step(); wdog_i = 0; idle(3);
    rd(3'd5, 'h10000, "R7"); wr(3'd2, 8'h00);
    cur_req = "R8";
    step(); fatal_i = 7'h01; step(); fatal_i = 0; idle(3);
    wr(3'd3, 8'h1F); step(); fatal_i = 7'h01; idle(3); fatal_i = 0; idle(2);
    wr(3'd3, 8'hF0); step(); fatal_i = 7'h4F; step(); fatal_i = 0; idle(3);
    rd(3'd5, 'h4000, "R8");
    cur_req = "R9";
    wr(3'd4, 8'h81); idle(4); rd(3'd5, 'h8000, "R9");
    wr(3'd4, 8'h00); wr(3'd4, 8'h01); idle(3); wr(3'd4, 8'h80); idle(3);
    cur_req = "R11";
    for (int a = 0; a < 8; a++) begin step(); reg_addr = 3'(a); step(); end
    reg_addr = 3'd5; idle(3);
    cur_req = "R1"; step(); rst_n = 0; idle(2); rd(3'd4, 0, "R1"); rst_n = 1;
    idle(3); rd(3'd5, 'h80, "R1"); rd(3'd3, 0, "R1");
    finish_run();
  end
endmodule